// File: doc/BRIEF.md
# Dual-Context Event Swap Unit

This unit keeps two peer execution contexts for a small processor core, each made of a program counter and a set of condition flags. Exactly one context is active at a time, and its PC and flags drive the fetch stage. A swap stores the active context's resume state and makes the other context active. Software can request a swap with a command, and a qualified hardware event line can also request one. The two contexts have equal standing: there is no stack, no nesting and no priority. A second swap always brings back the context that the first swap stored.

The core reports each instruction boundary together with the state at which the active context must resume. That resume state is the next instruction's PC when an instruction retires, or the PC of a waiting instruction when the context is stalled on a condition. Requests wait in a single pending bit and are acted on only at a boundary. For one cycle after a swap the unit signals a fetch redirect. During that cycle boundaries are ignored and any new request is held for later.

Top module: `ctx_swap_unit`

## Requirements
- R1: After reset, context 0 is active, `pc_o` equals the context-0 start address, `flags_o` is zero and `redirect_o` is low. Context 1 starts at its own start address with zero flags.
- R2: At a boundary (`bnd_i` high) with no swap taken, the active context's PC and flags take `resume_pc_i` and `resume_flags_i` in the next cycle, and `ctx_id_o` does not change.
- R3: A software request together with a boundary makes the other context active in the next cycle. `ctx_id_o` toggles, `pc_o` and `flags_o` show that context's stored state, and `redirect_o` is high for exactly that one cycle.
- R4: A swap stores the outgoing context's resume values from the boundary cycle. A later swap presents those values unchanged, so two swaps return to the original context.
- R5: A request that arrives without a boundary is held pending and causes no output change until the next boundary, where the swap is taken.
- R6: A rising edge on an event line qualifies as a swap request when that line's bit in `ev_mask_i` is 1 and `hw_en_i` is 1 in the cycle of the edge. Bit n of `ev_mask_i` selects line n of `ev_i`.
- R7: An event edge that arrives while `hw_en_i` is 0, or on a line whose mask bit is 0, is discarded and does not trigger a later swap.
- R8: In the redirect cycle, `bnd_i` is ignored: there is no context update and no swap. A request made in that cycle is held and is taken at the first boundary after it.
- R9: Several requests made before one boundary merge into a single swap. A following boundary with no new request does not swap again.
- R10: Software requests are acted on whatever the value of `hw_en_i`.
- R11: In a cycle with `bnd_i` low, `pc_o`, `flags_o` and `ctx_id_o` keep their values at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_i | input | 1 | Instruction boundary reached by the active context |
| resume_pc_i | input | 16 | PC at which the active context resumes |
| resume_flags_i | input | 4 | Flags with which the active context resumes |
| sw_swap_i | input | 1 | Software swap request |
| hw_en_i | input | 1 | Enable for swaps triggered by events |
| ev_mask_i | input | N_EV | Per-line event qualification mask |
| ev_i | input | N_EV | Hardware event lines |
| pc_o | output | 16 | Active context PC to fetch |
| flags_o | output | 4 | Active context flags |
| ctx_id_o | output | 1 | Index of the active context |
| redirect_o | output | 1 | High in the cycle after a swap |

## Verification
Every result has a latency of one register. A boundary or a swap taken at a clock edge changes `pc_o`, `flags_o`, `ctx_id_o` and `redirect_o` just after that edge, and `redirect_o` drops at the following edge. The bench drives each cycle's inputs at a falling edge and reads the outputs at the next falling edge, which is the earliest point at which the result of the edge in between can be seen. Held requests are observed over several idle cycles, to confirm that nothing changes before the boundary that serves them. A reference copy of the two context slots is updated only at points where the requirements call for a change.

// File: rtl/swap_pkg.sv
package swap_pkg;

    parameter int CTX_PC_W   = 16;
    parameter int CTX_FLAG_W = 4;
    localparam int CTX_WORD_W = CTX_PC_W + CTX_FLAG_W;

    // One context packs into a single word: PC in the upper bits, flags below.
    typedef struct packed {
        logic [CTX_PC_W-1:0]   pc;
        logic [CTX_FLAG_W-1:0] flags;
    } ctx_t;

    typedef enum logic {
        SW_IDLE     = 1'b0,
        SW_REDIRECT = 1'b1
    } swap_state_e;

    function automatic ctx_t ctx_init(input logic [CTX_PC_W-1:0] start);
        ctx_t c;
        c.pc    = start;
        c.flags = '0;
        return c;
    endfunction

endpackage

// File: rtl/swap_evq.sv
module swap_evq #(
    parameter int N_EV = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_EV-1:0] ev_i,
    input  logic [N_EV-1:0] mask_i,
    input  logic            en_i,
    output logic            hit_o
);
    logic [N_EV-1:0] ev_prev;
    logic [N_EV-1:0] line_hit;

    always_ff @(posedge clk) begin
        if (rst) ev_prev <= '0;
        else     ev_prev <= ev_i;
    end

    // A line counts only on its rising edge and only while its mask bit is set.
    for (genvar g = 0; g < N_EV; g++) begin : g_line
        assign line_hit[g] = ev_i[g] & ~ev_prev[g] & mask_i[g];
    end

    assign hit_o = en_i & (|line_hit);

endmodule

// File: rtl/swap_ctl.sv
module swap_ctl
    import swap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bnd_i,
    input  logic sw_req_i,
    input  logic hw_req_i,
    output logic take_o,
    output logic upd_o,
    output logic redirect_o
);
    swap_state_e state;
    logic        pend;
    logic        req_now;

    assign req_now    = sw_req_i | hw_req_i;
    assign redirect_o = (state == SW_REDIRECT);
    assign upd_o      = bnd_i & ~redirect_o;
    assign take_o     = upd_o & (pend | req_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_IDLE;
            pend  <= 1'b0;
        end else begin
            state <= take_o ? SW_REDIRECT : SW_IDLE;
            if (take_o) pend <= 1'b0;
            else        pend <= pend | req_now;
        end
    end

endmodule

// File: rtl/swap_ctx_bank.sv
module swap_ctx_bank
    import swap_pkg::*;
#(
    parameter logic [CTX_PC_W-1:0] START0 = '0,
    parameter logic [CTX_PC_W-1:0] START1 = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic upd_i,
    input  logic take_i,
    input  ctx_t resume_i,
    output ctx_t active_o,
    output logic act_o
);
    localparam int N_CTX = 2;

    ctx_t slot [N_CTX];
    logic act;

    for (genvar g = 0; g < N_CTX; g++) begin : g_slot
        localparam logic [CTX_PC_W-1:0] START = (g == 0) ? START0 : START1;
        always_ff @(posedge clk) begin
            if (rst)                              slot[g] <= ctx_init(START);
            else if (upd_i && (act == 1'(g)))     slot[g] <= resume_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         act <= 1'b0;
        else if (take_i) act <= ~act;
    end

    assign active_o = slot[act];
    assign act_o    = act;

endmodule

// File: rtl/ctx_swap_unit.sv
module ctx_swap_unit
    import swap_pkg::*;
#(
    parameter int                  N_EV   = 4,
    parameter logic [CTX_PC_W-1:0] START0 = 16'h0000,
    parameter logic [CTX_PC_W-1:0] START1 = 16'h0800
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bnd_i,
    input  logic [CTX_PC_W-1:0]   resume_pc_i,
    input  logic [CTX_FLAG_W-1:0] resume_flags_i,
    input  logic                  sw_swap_i,
    input  logic                  hw_en_i,
    input  logic [N_EV-1:0]       ev_mask_i,
    input  logic [N_EV-1:0]       ev_i,
    output logic [CTX_PC_W-1:0]   pc_o,
    output logic [CTX_FLAG_W-1:0] flags_o,
    output logic                  ctx_id_o,
    output logic                  redirect_o
);
    logic hw_req, take, upd;
    ctx_t resume, active;

    assign resume.pc    = resume_pc_i;
    assign resume.flags = resume_flags_i;

    swap_evq #(.N_EV(N_EV)) u_evq (
        .clk    (clk),
        .rst    (rst),
        .ev_i   (ev_i),
        .mask_i (ev_mask_i),
        .en_i   (hw_en_i),
        .hit_o  (hw_req)
    );

    swap_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .bnd_i      (bnd_i),
        .sw_req_i   (sw_swap_i),
        .hw_req_i   (hw_req),
        .take_o     (take),
        .upd_o      (upd),
        .redirect_o (redirect_o)
    );

    swap_ctx_bank #(.START0(START0), .START1(START1)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (upd),
        .take_i   (take),
        .resume_i (resume),
        .active_o (active),
        .act_o    (ctx_id_o)
    );

    assign pc_o    = active.pc;
    assign flags_o = active.flags;

endmodule

// File: rtl/swap_unit_chk.sv
module swap_unit_chk
    import swap_pkg::*;
#(
    parameter logic [CTX_PC_W-1:0] START0 = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  bnd_i,
    input logic                  sw_swap_i,
    input logic [CTX_PC_W-1:0]   pc_o,
    input logic [CTX_FLAG_W-1:0] flags_o,
    input logic                  ctx_id_o,
    input logic                  redirect_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctx_id_o == 1'b0 && pc_o == START0 && flags_o == '0 && !redirect_o));

    // R3
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> !redirect_o);

    // R3
    ctx_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_id_o != $past(ctx_id_o)) |-> redirect_o);

    // R8
    redirect_hold_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_o |=> ($stable(ctx_id_o) && $stable(pc_o) && $stable(flags_o)));

    // R10
    sw_take_chk: assert property (@(posedge clk) disable iff (rst)
        (bnd_i && sw_swap_i && !redirect_o) |=> redirect_o);

    // R11
    no_bnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bnd_i |=> ($stable(pc_o) && $stable(flags_o) && $stable(ctx_id_o)));

endmodule

bind ctx_swap_unit swap_unit_chk #(.START0(START0)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bnd_i      (bnd_i),
    .sw_swap_i  (sw_swap_i),
    .pc_o       (pc_o),
    .flags_o    (flags_o),
    .ctx_id_o   (ctx_id_o),
    .redirect_o (redirect_o)
);

// File: tb/tb_ctx_swap_unit.sv
module tb_ctx_swap_unit;
    localparam logic [15:0] S0 = 16'h0000;
    localparam logic [15:0] S1 = 16'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bnd = 1'b0;
    logic [15:0] rpc = '0;
    logic [3:0]  rfl = '0;
    logic        sw = 1'b0;
    logic        hw_en = 1'b0;
    logic [3:0]  mask = '0;
    logic [3:0]  ev = '0;
    logic [15:0] pc_o;
    logic [3:0]  flags_o;
    logic        ctx_id_o, redirect_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctx_swap_unit #(.N_EV(4), .START0(S0), .START1(S1)) dut (
        .clk(clk), .rst(rst), .bnd_i(bnd), .resume_pc_i(rpc), .resume_flags_i(rfl),
        .sw_swap_i(sw), .hw_en_i(hw_en), .ev_mask_i(mask), .ev_i(ev),
        .pc_o(pc_o), .flags_o(flags_o), .ctx_id_o(ctx_id_o), .redirect_o(redirect_o)
    );

    // Drive one cycle's inputs at a falling edge, then wait for the next one.
    task automatic cyc(input logic b, input logic [15:0] p, input logic [3:0] f,
                       input logic s, input logic [3:0] e);
        bnd = b; rpc = p; rfl = f; sw = s; ev = e;
        @(negedge clk);
    endtask

    task automatic expect_st(input string tag, input logic c, input logic [15:0] p,
                             input logic [3:0] f, input logic rd);
        checks++;
        if (ctx_id_o !== c || pc_o !== p || flags_o !== f || redirect_o !== rd) begin
            errors++;
            $display("FAIL %s: got ctx=%0d pc=%h fl=%h rd=%0d, expected ctx=%0d pc=%h fl=%h rd=%0d",
                     tag, ctx_id_o, pc_o, flags_o, redirect_o, c, p, f, rd);
        end
    endtask

    task automatic t_reset();
        expect_st("R1 reset state", 1'b0, S0, 4'h0, 1'b0);
    endtask

    task automatic t_plain_boundary();
        cyc(1, 16'h0123, 4'h5, 0, 0);
        expect_st("R2 boundary update", 1'b0, 16'h0123, 4'h5, 1'b0);
        cyc(0, 16'hFFFF, 4'hF, 0, 0);
        expect_st("R11 hold without boundary", 1'b0, 16'h0123, 4'h5, 1'b0);
    endtask

    task automatic t_sw_swap();
        cyc(1, 16'h0200, 4'h3, 1, 0);
        expect_st("R3 swap to ctx1", 1'b1, S1, 4'h0, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
        expect_st("R3 redirect one cycle", 1'b1, S1, 4'h0, 1'b0);
    endtask

    task automatic t_swap_back();
        cyc(1, 16'h0810, 4'h9, 1, 0);
        expect_st("R4 swap back restores ctx0", 1'b0, 16'h0200, 4'h3, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
        cyc(1, 16'h0204, 4'h1, 1, 0);
        expect_st("R4 ctx1 saved state returns", 1'b1, 16'h0810, 4'h9, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
    endtask

    task automatic t_pending();
        cyc(0, 16'h0, 4'h0, 1, 0);
        expect_st("R5 no change before boundary", 1'b1, 16'h0810, 4'h9, 1'b0);
        for (int i = 0; i < 3; i++) begin
            cyc(0, 16'h0, 4'h0, 0, 0);
        end
        expect_st("R5 still held", 1'b1, 16'h0810, 4'h9, 1'b0);
        cyc(1, 16'h0814, 4'h2, 0, 0);
        expect_st("R5 held request taken", 1'b0, 16'h0204, 4'h1, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
    endtask

    task automatic t_hw_event();
        hw_en = 1'b1; mask = 4'b0010;
        cyc(0, 16'h0, 4'h0, 0, 4'b0010);
        expect_st("R6 edge alone no change", 1'b0, 16'h0204, 4'h1, 1'b0);
        cyc(0, 16'h0, 4'h0, 0, 0);
        cyc(1, 16'h0208, 4'h6, 0, 0);
        expect_st("R6 event swap", 1'b1, 16'h0814, 4'h2, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
    endtask

    task automatic t_discard();
        hw_en = 1'b0;
        cyc(0, 16'h0, 4'h0, 0, 4'b0010);
        cyc(0, 16'h0, 4'h0, 0, 0);
        hw_en = 1'b1; mask = 4'b0010;
        cyc(0, 16'h0, 4'h0, 0, 4'b0100);
        cyc(0, 16'h0, 4'h0, 0, 0);
        cyc(1, 16'h0818, 4'h7, 0, 0);
        expect_st("R7 discarded edges no swap", 1'b1, 16'h0818, 4'h7, 1'b0);
    endtask

    task automatic t_redirect_window();
        cyc(1, 16'h081C, 4'h4, 1, 0);
        expect_st("R8 first swap", 1'b0, 16'h0208, 4'h6, 1'b1);
        cyc(1, 16'h0300, 4'h8, 1, 0);
        expect_st("R8 boundary ignored in redirect", 1'b0, 16'h0208, 4'h6, 1'b0);
        cyc(1, 16'h020C, 4'h5, 0, 0);
        expect_st("R8 held request taken after", 1'b1, 16'h081C, 4'h4, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
    endtask

    task automatic t_coalesce();
        hw_en = 1'b1; mask = 4'b0010;
        cyc(0, 16'h0, 4'h0, 1, 0);
        cyc(0, 16'h0, 4'h0, 0, 4'b0010);
        cyc(0, 16'h0, 4'h0, 0, 0);
        cyc(1, 16'h0820, 4'hA, 0, 0);
        expect_st("R9 one swap for merged requests", 1'b0, 16'h020C, 4'h5, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
        cyc(1, 16'h0210, 4'hB, 0, 0);
        expect_st("R9 no second swap", 1'b0, 16'h0210, 4'hB, 1'b0);
    endtask

    task automatic t_sw_without_en();
        hw_en = 1'b0;
        cyc(1, 16'h0214, 4'hC, 1, 0);
        expect_st("R10 software swap with events disabled", 1'b1, 16'h0820, 4'hA, 1'b1);
        cyc(0, 16'h0, 4'h0, 0, 0);
        expect_st("R10 settled", 1'b1, 16'h0820, 4'hA, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain_boundary();
        t_sw_swap();
        t_swap_back();
        t_pending();
        t_hw_event();
        t_discard();
        t_redirect_window();
        t_coalesce();
        t_sw_without_en();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule